// File: doc/BRIEF.md
# Adaptive Pulse-and-Verify ROM Programming Sequencer

This block drives the control pins of a word-wide programmable ROM so that an image held in a separate memory ends up burned into it. Once started, it visits ROM addresses in ascending order. At each address it fetches the image word. A word that is all ones is already satisfied by the erased array and is passed over. Any other word receives fixed-length program pulses. Each pulse is followed by a read-back, and pulsing continues until the read-back equals the image word or a bounded pulse budget is used up.

The per-address phase runs with the elevated-supply select raised. When the last address is finished, the select drops to nominal and every address is read once more and compared with the image. A clean final pass produces a single-cycle completion strobe. An exhausted pulse budget or a final-pass mismatch stops the run with a sticky error and the offending address held on an output. The image port is a combinational read: `imgData` reflects `imgAddr` in the same cycle. Supply switching appears only as two digital enables.

Top module: `burnSequencer`

## Requirements
- R1: After reset the block is idle with `romCeN`=1, `romOeN`=1 (both active low), `vppEn`=0, `vccHigh`=0, `romDataOe`=0, `done`=0 and `error`=0.
- R2: A program pulse holds `romCeN`=0, `romOeN`=1, `vppEn`=1 and `romDataOe`=1 for exactly `PULSE_CYCLES` consecutive cycles, with `romDout` equal to the image word of `romAddr`.
- R3: After every pulse the word is read back with `romCeN`=1, `romOeN`=0, `vppEn`=1. A mismatch leads to another pulse, and a match moves on, so an address whose cells need k pulses (k ≤ `MAX_PULSES`) receives exactly k.
- R4: If the read-back still differs after `MAX_PULSES` pulses, the run stops. `error` rises and stays high until the next `start`, `failAddr` holds that address, no further pulses occur, and all ROM control pins return to their idle levels.
- R5: Addresses are processed in ascending order from 0 to 2^`ADDR_W`-1, and the pulsed address never decreases within a run.
- R6: `vccHigh` is 1 throughout every pulse. In the final pass, each address is read in ascending order with `romCeN`=0, `romOeN`=0, `vppEn`=0 and `vccHigh`=0.
- R7: A mismatch in the final pass stops the run with `error`=1, `failAddr` equal to that address, and no `done`.
- R8: An image word of all ones (0xFFFF at the default width) gets no program pulse.
- R9: After a final pass without mismatch, `done` is high for exactly one cycle, once per run.
- R10: `start` is ignored while a run is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a run when idle |
| done | output | 1 | One-cycle strobe on successful completion |
| error | output | 1 | Sticky failure flag, cleared by start |
| failAddr | output | ADDR_W | Address at which the run failed |
| imgAddr | output | ADDR_W | Image read address |
| imgData | input | DATA_W | Image word at imgAddr (combinational) |
| romAddr | output | ADDR_W | ROM address |
| romDout | output | DATA_W | Data driven to the ROM during a pulse |
| romDin | input | DATA_W | Data read from the ROM |
| romDataOe | output | 1 | Enables the data driver toward the ROM |
| romCeN | output | 1 | ROM chip enable, active low |
| romOeN | output | 1 | ROM output enable, active low |
| vppEn | output | 1 | Program-voltage enable |
| vccHigh | output | 1 | Elevated-supply select |

## Verification
The bench supplies a random image with scattered all-ones words and gives each address a random number of pulses it needs before its cells take the data. This separates correct adaptive pulse counts from fixed or off-by-one counts, and it separates skipping from pulsing. One address is set to need exactly the pulse budget, which tells the last permitted pulse apart from the limit. A second image has a cell that never programs, which must trip the limit at a known address. A third has a cell that reads correctly only at the elevated supply, so only the final nominal pass can catch it. An all-ones image and a `start` issued mid-run check skipping and the refusal to restart.

// File: rtl/burnPkg.sv
package burnPkg;

  typedef enum logic [3:0] {
    S_IDLE, S_SCAN, S_PULSE, S_VSET, S_VCHK, S_NEXT, S_FSET, S_FCHK, S_DONE, S_FAIL
  } burnState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic addrClr;
    logic addrInc;
    logic timerClr;
    logic pcntClr;
    logic pcntInc;
    logic latchFail;
    logic clrErr;
  } dpCtrl_t;

  // status from datapath to control
  typedef struct packed {
    logic timerDone;
    logic pcntMax;
    logic wordMatch;
    logic addrLast;
    logic imgBlank;
  } dpStat_t;

endpackage

// File: rtl/burnDatapath.sv
module burnDatapath
  import burnPkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int PULSE_CYCLES = 5000,
  parameter int MAX_PULSES   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtrl_t           ctrl,
  input  logic [DATA_W-1:0] imgData,
  input  logic [DATA_W-1:0] romDin,
  output dpStat_t           stat,
  output logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] failAddr,
  output logic              error
);

  localparam int TMR_W  = $clog2(PULSE_CYCLES + 1);
  localparam int PCNT_W = $clog2(MAX_PULSES + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};
  localparam logic [TMR_W-1:0]  TMR_END   = TMR_W'(PULSE_CYCLES - 1);
  localparam logic [PCNT_W-1:0] PCNT_END  = PCNT_W'(MAX_PULSES);

  logic [TMR_W-1:0]  timer;
  logic [PCNT_W-1:0] pcnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              addr <= '0;
    else if (ctrl.addrClr)  addr <= '0;
    else if (ctrl.addrInc)  addr <= addr + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 timer <= '0;
    else if (ctrl.timerClr)    timer <= '0;
    else if (!stat.timerDone)  timer <= timer + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             pcnt <= '0;
    else if (ctrl.pcntClr) pcnt <= '0;
    else if (ctrl.pcntInc) pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      error    <= 1'b0;
      failAddr <= '0;
    end else if (ctrl.clrErr) begin
      error    <= 1'b0;
    end else if (ctrl.latchFail) begin
      error    <= 1'b1;
      failAddr <= addr;
    end
  end

  always_comb begin
    stat.timerDone = (timer == TMR_END);
    stat.pcntMax   = (pcnt == PCNT_END);
    stat.wordMatch = (romDin == imgData);
    stat.addrLast  = (addr == LAST_ADDR);
    stat.imgBlank  = &imgData;
  end

  // pulse budget is never exceeded
  assert_pulse_budget_R4: assert property (@(posedge clk) disable iff (!rstN)
    pcnt <= PCNT_END);

  // address only steps up by one or restarts at zero
  assert_addr_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (addr != $past(addr)) |-> (addr == ADDR_W'($past(addr) + 1'b1) || addr == '0));

  // a latched failure keeps its address until cleared
  assert_fail_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (error && $past(error) && !ctrl.latchFail) |-> $stable(failAddr));

endmodule

// File: rtl/burnControl.sv
module burnControl
  import burnPkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  dpStat_t stat,
  output dpCtrl_t ctrl,
  output logic    done,
  output logic    romDataOe,
  output logic    romCeN,
  output logic    romOeN,
  output logic    vppEn,
  output logic    vccHigh
);

  burnState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl      = '0;
    unique case (state)
      S_IDLE: if (start) begin
        ctrl.clrErr  = 1'b1;
        ctrl.addrClr = 1'b1;
        stateNext    = S_SCAN;
      end
      S_SCAN: begin
        if (stat.imgBlank) stateNext = S_NEXT;
        else begin
          ctrl.pcntClr  = 1'b1;
          ctrl.timerClr = 1'b1;
          stateNext     = S_PULSE;
        end
      end
      S_PULSE: if (stat.timerDone) begin
        ctrl.pcntInc = 1'b1;
        stateNext    = S_VSET;
      end
      S_VSET: stateNext = S_VCHK;
      S_VCHK: begin
        if (stat.wordMatch) stateNext = S_NEXT;
        else if (stat.pcntMax) begin
          ctrl.latchFail = 1'b1;
          stateNext      = S_FAIL;
        end else begin
          ctrl.timerClr = 1'b1;
          stateNext     = S_PULSE;
        end
      end
      S_NEXT: begin
        if (stat.addrLast) begin
          ctrl.addrClr = 1'b1;
          stateNext    = S_FSET;
        end else begin
          ctrl.addrInc = 1'b1;
          stateNext    = S_SCAN;
        end
      end
      S_FSET: stateNext = S_FCHK;
      S_FCHK: begin
        if (!stat.wordMatch) begin
          ctrl.latchFail = 1'b1;
          stateNext      = S_FAIL;
        end else if (stat.addrLast) stateNext = S_DONE;
        else begin
          ctrl.addrInc = 1'b1;
          stateNext    = S_FSET;
        end
      end
      S_DONE:  stateNext = S_IDLE;
      S_FAIL:  stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_comb begin
    romCeN    = 1'b1;
    romOeN    = 1'b1;
    vppEn     = 1'b0;
    vccHigh   = 1'b0;
    romDataOe = 1'b0;
    done      = (state == S_DONE);
    unique case (state)
      S_PULSE: begin
        romCeN    = 1'b0;
        vppEn     = 1'b1;
        vccHigh   = 1'b1;
        romDataOe = 1'b1;
      end
      S_VSET, S_VCHK: begin
        romOeN  = 1'b0;
        vppEn   = 1'b1;
        vccHigh = 1'b1;
      end
      S_SCAN, S_NEXT: vccHigh = 1'b1;
      S_FSET, S_FCHK: begin
        romCeN = 1'b0;
        romOeN = 1'b0;
      end
      default: ;
    endcase
  end

  // a pulse is not cut short before its timer expires
  assert_pulse_len_R2: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PULSE && !stat.timerDone) |=> (state == S_PULSE));

  // failed read-back with budget left gives another pulse
  assert_repulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_VCHK && !stat.wordMatch && !stat.pcntMax) |=> (state == S_PULSE));

  // blank image word never reaches a pulse
  assert_skip_blank_R8: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_SCAN && stat.imgBlank) |=> (state != S_PULSE));

  // completion strobe lasts one cycle and follows a final compare
  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_origin_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(state) == S_FCHK && $past(stat.wordMatch)));

  // start while busy does not disturb the run
  assert_busy_start_R10: assert property (@(posedge clk) disable iff (!rstN)
    (start && state != S_IDLE && state != S_DONE && state != S_FAIL) |=> (state != S_SCAN || $past(state) == S_NEXT));

endmodule

// File: rtl/burnSequencer.sv
module burnSequencer
  import burnPkg::*;
#(
  parameter int ADDR_W       = 18,
  parameter int DATA_W       = 16,
  parameter int PULSE_CYCLES = 5000,
  parameter int MAX_PULSES   = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] failAddr,
  output logic [ADDR_W-1:0] imgAddr,
  input  logic [DATA_W-1:0] imgData,
  output logic [ADDR_W-1:0] romAddr,
  output logic [DATA_W-1:0] romDout,
  input  logic [DATA_W-1:0] romDin,
  output logic              romDataOe,
  output logic              romCeN,
  output logic              romOeN,
  output logic              vppEn,
  output logic              vccHigh
);

  dpCtrl_t           ctrl;
  dpStat_t           stat;
  logic [ADDR_W-1:0] addr;

  burnControl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .stat      (stat),
    .ctrl      (ctrl),
    .done      (done),
    .romDataOe (romDataOe),
    .romCeN    (romCeN),
    .romOeN    (romOeN),
    .vppEn     (vppEn),
    .vccHigh   (vccHigh)
  );

  burnDatapath #(
    .ADDR_W       (ADDR_W),
    .DATA_W       (DATA_W),
    .PULSE_CYCLES (PULSE_CYCLES),
    .MAX_PULSES   (MAX_PULSES)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .imgData  (imgData),
    .romDin   (romDin),
    .stat     (stat),
    .addr     (addr),
    .failAddr (failAddr),
    .error    (error)
  );

  assign imgAddr = addr;
  assign romAddr = addr;
  assign romDout = imgData;

endmodule

// File: tb/burnSequencer_bench.sv
`timescale 1ns/1ps
module burnSequencer_bench;

  localparam int AW = 4;
  localparam int DW = 16;
  localparam int PW = 4;
  localparam int MAXP = 6;
  localparam int N = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic done, error, romDataOe, romCeN, romOeN, vppEn, vccHigh;
  logic [AW-1:0] failAddr, imgAddr, romAddr;
  logic [DW-1:0] imgData, romDout, romDin;

  always #10 clk = ~clk;

  burnSequencer #(.ADDR_W(AW), .DATA_W(DW), .PULSE_CYCLES(PW), .MAX_PULSES(MAXP)) u_burnSequencer (
    .clk(clk), .rstN(rstN), .start(start), .done(done), .error(error), .failAddr(failAddr),
    .imgAddr(imgAddr), .imgData(imgData), .romAddr(romAddr), .romDout(romDout), .romDin(romDin),
    .romDataOe(romDataOe), .romCeN(romCeN), .romOeN(romOeN), .vppEn(vppEn), .vccHigh(vccHigh)
  );

  // image and ROM model
  logic [DW-1:0] img [N];
  logic [DW-1:0] mem [N];
  int need [N];
  int got [N];
  int pulses [N];
  bit finalSeen [N];
  bit weakOn = 1'b0;
  logic [AW-1:0] weakAddr = '0;

  assign imgData = img[imgAddr];
  assign romDin  = (weakOn && !vccHigh && romAddr == weakAddr) ? ~mem[romAddr] : mem[romAddr];

  int checks = 0;
  int fails = 0;

  // monitor state
  int pulseLen = 0;
  int pulseAddr = 0;
  int lastPulse = -1;
  int lastFinal = -1;
  int doneCnt = 0;
  int doneRun = 0;
  int doneMaxW = 0;
  bit widthBad, dataBad, supplyBad, orderBad, finalBad, finalOrderBad;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!romCeN && romOeN && vppEn) begin
      pulseLen++;
      pulseAddr = int'(romAddr);
      if (!romDataOe || romDout != img[romAddr]) dataBad = 1'b1;
      if (!vccHigh) supplyBad = 1'b1;
    end else if (pulseLen > 0) begin
      if (pulseLen != PW) widthBad = 1'b1;
      if (pulseAddr < lastPulse) orderBad = 1'b1;
      lastPulse = pulseAddr;
      pulses[pulseAddr]++;
      got[pulseAddr]++;
      if (got[pulseAddr] >= need[pulseAddr]) mem[pulseAddr] = mem[pulseAddr] & img[pulseAddr];
      pulseLen = 0;
    end
    if (!romCeN && !romOeN) begin
      if (vppEn || vccHigh) finalBad = 1'b1;
      if (int'(romAddr) < lastFinal) finalOrderBad = 1'b1;
      lastFinal = int'(romAddr);
      finalSeen[romAddr] = 1'b1;
    end
    if (done) begin
      doneRun++;
      if (doneRun == 1) doneCnt++;
      if (doneRun > doneMaxW) doneMaxW = doneRun;
    end else doneRun = 0;
  end

  function automatic int expPulses(input int a);
    if (img[a] == {DW{1'b1}}) return 0;
    return (need[a] < MAXP) ? need[a] : MAXP;
  endfunction

  task automatic prep(input int kind);
    for (int i = 0; i < N; i++) begin
      img[i]  = DW'($urandom);
      if (img[i] == {DW{1'b1}}) img[i] = 16'h1234;
      if (i % 5 == 3) img[i] = {DW{1'b1}};
      need[i] = 1 + int'($urandom % 5);
      got[i] = 0; pulses[i] = 0; finalSeen[i] = 1'b0;
      mem[i] = {DW{1'b1}};
      if (kind == 3) img[i] = {DW{1'b1}};
    end
    need[7] = MAXP;
    weakOn = 1'b0;
    if (kind == 1) need[5] = MAXP + 1;
    if (kind == 2) begin weakOn = 1'b1; weakAddr = 4'd9; end
    pulseLen = 0; lastPulse = -1; lastFinal = -1;
    doneCnt = 0; doneRun = 0; doneMaxW = 0;
    widthBad = 0; dataBad = 0; supplyBad = 0; orderBad = 0; finalBad = 0; finalOrderBad = 0;
  endtask

  task automatic kick();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitEnd(input bit busyStart);
    int n = 0;
    bit fin = 1'b0;
    while (!fin && n < 5000) begin
      @(negedge clk); #1;
      n++;
      if (busyStart && n == 30) start = 1'b1;
      if (busyStart && n == 31) start = 1'b0;
      if (doneCnt > 0 || error) fin = 1'b1;
    end
    check(fin, "R9", "run finished before timeout", n, 0);
    repeat (3) @(negedge clk);
    #1;
  endtask

  task automatic checkIdle(input string req);
    check(romCeN && romOeN && !vppEn && !vccHigh && !romDataOe, req, "control pins idle",
          {romCeN, romOeN, vppEn, vccHigh, romDataOe}, 5'b11000);
  endtask

  initial begin
    int badCnt, sumAct, sumExp;
    void'($urandom(32'd1357));
    for (int i = 0; i < N; i++) begin
      img[i] = '1; mem[i] = '1; need[i] = 1; got[i] = 0; pulses[i] = 0; finalSeen[i] = 0;
    end
    repeat (3) @(negedge clk);
    #1;
    // R1 reset state
    check(romCeN && romOeN && !vppEn && !vccHigh && !romDataOe, "R1", "pins in reset",
          {romCeN, romOeN, vppEn, vccHigh, romDataOe}, 5'b11000);
    check(!done && !error, "R1", "flags in reset", {done, error}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // scenario 0: random image, boundary need at addr 7, start while busy
    prep(0);
    kick();
    waitEnd(1'b1);
    badCnt = 0; sumAct = 0; sumExp = 0;
    for (int a = 0; a < N; a++) begin
      if (pulses[a] != expPulses(a)) badCnt++;
      sumAct += pulses[a]; sumExp += expPulses(a);
    end
    check(badCnt == 0, "R3", "addresses with wrong pulse count", badCnt, 0);
    check(pulses[7] == MAXP, "R3", "pulses at budget-limit address", pulses[7], MAXP);
    check(pulses[3] == 0 && pulses[8] == 0, "R8", "pulses at blank words", pulses[3] + pulses[8], 0);
    check(!widthBad, "R2", "pulse width", widthBad, 0);
    check(!dataBad, "R2", "pulse data and driver", dataBad, 0);
    check(!supplyBad, "R6", "elevated supply during pulse", supplyBad, 0);
    check(!orderBad, "R5", "pulse address order", orderBad, 0);
    check(sumAct == sumExp && !orderBad, "R10", "total pulses with busy start", sumAct, sumExp);
    badCnt = 0;
    for (int a = 0; a < N; a++) if (!finalSeen[a]) badCnt++;
    check(badCnt == 0, "R6", "addresses missed in final pass", badCnt, 0);
    check(!finalBad && !finalOrderBad, "R6", "final pass pins and order", finalBad + finalOrderBad, 0);
    check(doneCnt == 1 && doneMaxW == 1, "R9", "done strobes and width", doneCnt * 10 + doneMaxW, 11);
    check(!error, "R9", "no error on success", error, 0);
    checkIdle("R9");

    // scenario 1: address 5 never programs
    prep(1);
    kick();
    waitEnd(1'b0);
    check(error, "R4", "error after budget", error, 1);
    check(failAddr == 4'd5, "R4", "failing address", failAddr, 5);
    check(pulses[5] == MAXP, "R4", "pulses at stuck address", pulses[5], MAXP);
    badCnt = 0;
    for (int a = 6; a < N; a++) badCnt += pulses[a];
    check(badCnt == 0, "R4", "pulses after failure", badCnt, 0);
    check(doneCnt == 0, "R4", "no done after failure", doneCnt, 0);
    checkIdle("R4");
    repeat (5) @(negedge clk);
    #1;
    check(error, "R4", "error sticky while idle", error, 1);

    // scenario 2: word 9 reads wrong at nominal supply only
    prep(2);
    kick();
    #1;
    check(!error, "R4", "error cleared by start", error, 0);
    waitEnd(1'b0);
    check(pulses[9] == expPulses(9), "R3", "weak word programmed normally", pulses[9], expPulses(9));
    check(error && failAddr == 4'd9, "R7", "final mismatch address", failAddr, 9);
    check(doneCnt == 0, "R7", "no done on final mismatch", doneCnt, 0);
    check(finalSeen[8] && !finalSeen[10], "R7", "final pass stopped at mismatch", finalSeen[10], 0);
    checkIdle("R7");

    // scenario 3: fully blank image
    prep(3);
    kick();
    waitEnd(1'b0);
    sumAct = 0;
    for (int a = 0; a < N; a++) sumAct += pulses[a];
    check(sumAct == 0, "R8", "pulses on blank image", sumAct, 0);
    check(doneCnt == 1 && !error, "R9", "blank image completes", doneCnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule